// File: doc/BRIEF.md
# Dual-Processor Interrupt and Interval Timer Controller

This block raises interrupts for two processors that share one interval timer. It has four interrupt sources: the timer, a level-sensitive sound interrupt, a sprite event and a vertical-blank event. Each processor has its own enable mask and its own set of interrupt lines, with one line per source. The timer is a 12-bit up-counter. A two-bit mode selects what it counts: it can stand still, count horizontal-sync pulses, or count a dedicated timer clock. When the count passes its top value the counter restarts from a programmable start value and signals both processors.

A host reaches four word registers through a small strobe interface. The registers are the restart value, the counting mode, the mask of processor A and the mask of processor B. A read at any offset returns the live count. A read at a processor's mask offset also clears that processor's timer request. A scanline strobe with a line number drives the two video events. A separate clear input drops both video events.

Top module: `twin_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset the count, restart value, mode and both masks are zero, all requests are clear, and every interrupt output is low.
- R2: A write at offset 0 stores the 12-bit restart value. It does not change the current count. It is used at the next wrap.
- R3: A write at offset 1 sets the mode from bits [1:0]: 0 stops the counter, 1 counts `hsync_tick` and 3 counts `timer_tick`. Value 2 counts nothing. A read at any offset returns the count on `host_rdata`, which always shows the count.
- R4: A count step taken while the count is 0xFFF wraps the counter. The counter loads the stored restart value and the timer fires.
- R5: A mode write that moves a nonzero mode to 0 advances the count by exactly one step. If that step wraps the counter, the timer fires in the same cycle.
- R6: When the timer fires, the timer request of both processors is set. Line bit 0 of each processor is that request ANDed with its mask bit 0.
- R7: A write at offset 2 (processor A) or offset 3 (processor B) stores `host_wdata[3:0]` as the mask. The mask bits are: bit 0 timer, bit 1 sound, bit 2 vblank, bit 3 sprite. The same write clears that processor's timer request. If the timer fires in the same cycle, the request stays set.
- R8: A read at offset 2 or 3 clears the timer request of processor A or processor B. The fire-wins rule applies here too.
- R9: A `line_stb` with `line_num` 0 sets the sprite event, and one with `line_num` 384 sets the vblank event. Output bits 3 and 2 are these events ANDed with the mask. `line_clr` clears both events, but a strobe in the same cycle wins.
- R10: Output bit 1 of each processor equals `snd_irq` one cycle earlier, ANDed with that processor's mask bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 2 | Register offset |
| host_wdata | input | 12 | Write data |
| host_rdata | output | 12 | Live timer count |
| hsync_tick | input | 1 | One-cycle horizontal-sync pulse |
| timer_tick | input | 1 | One-cycle timer clock enable |
| line_stb | input | 1 | Scanline strobe |
| line_num | input | 9 | Current scanline number |
| line_clr | input | 1 | Clears sprite and vblank events |
| snd_irq | input | 1 | Sound interrupt level |
| irq_a | output | 4 | Processor A lines: [0] timer, [1] sound, [2] vblank, [3] sprite |
| irq_b | output | 4 | Processor B lines, same bit order |

## Verification
A corrupted count shows on `host_rdata` in the very next cycle, because reads return the counter directly. A wrong restart value stays hidden until the next wrap, which can be up to 4096 count steps later. Broken request or event flags show on the matching `irq_a`/`irq_b` bit one cycle after the stimulus. A fault there can stay hidden while the mask bit is clear. The bench therefore runs with masks that enable the lines and compares all outputs every cycle against a model built from the requirements.

// File: rtl/irqt_pkg.sv
`timescale 1ns/1ps
// Shared constants for the dual-processor interrupt timer.
// Assumes four sources and a two-bit host offset space.
package irqt_pkg;
    localparam int NSRC   = 4;
    localparam int ADDR_W = 2;

    // Source index within a processor's line vector and mask
    localparam int SRC_TIMER  = 0;
    localparam int SRC_SOUND  = 1;
    localparam int SRC_VBLANK = 2;
    localparam int SRC_SPRITE = 3;

    typedef enum logic [1:0] {
        TM_STOP  = 2'd0,
        TM_HSYNC = 2'd1,
        TM_RSVD  = 2'd2,
        TM_CLOCK = 2'd3
    } tmode_e;

    localparam logic [ADDR_W-1:0] OFS_RELOAD = 2'd0;
    localparam logic [ADDR_W-1:0] OFS_MODE   = 2'd1;
    localparam logic [ADDR_W-1:0] OFS_MASK0  = 2'd2;
endpackage

// File: rtl/interval_timer.sv
`timescale 1ns/1ps
// Reloadable up-counter of CNT_W bits, shared by both processors.
// It fires on the step past all-ones and restarts from the stored
// restart value. Leaving a running mode for the stopped mode takes
// one final step. Assumes the tick inputs are single-cycle enables.
module interval_timer
    import irqt_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload_we,
    input  logic [CNT_W-1:0] reload_d,
    input  logic             mode_we,
    input  logic [1:0]       mode_d,
    input  logic             hsync_tick,
    input  logic             timer_tick,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] reload_o,
    output logic [1:0]       mode_o,
    output logic             fire_o
);
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] reload_q;
    tmode_e           mode_q;
    logic             adv;
    logic             last_step;
    logic             step;

    // Decide whether the counter moves this cycle and whether it wraps
    always_comb begin
        adv       = (mode_q == TM_HSYNC && hsync_tick) ||
                    (mode_q == TM_CLOCK && timer_tick);
        last_step = mode_we && (mode_q != TM_STOP) && (mode_d == 2'd0);
        step      = adv || last_step;
        fire_o    = step && (&count_q);
    end

    // Counter, restart value and mode registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q  <= '0;
            reload_q <= '0;
            mode_q   <= TM_STOP;
        end else begin
            if (fire_o)
                count_q <= reload_q;
            else if (step)
                count_q <= count_q + 1'b1;
            if (reload_we)
                reload_q <= reload_d;
            if (mode_we)
                mode_q <= tmode_e'(mode_d);
        end
    end

    assign count_o  = count_q;
    assign reload_o = reload_q;
    assign mode_o   = mode_q;
endmodule

// File: rtl/scan_events.sv
`timescale 1ns/1ps
// Video event flags and the sound level sample.
// The sprite and vblank flags are set by a strobe on their fixed
// scanlines and dropped by a common clear; a set wins over a clear.
// The sound level is registered once. Assumes line_num is stable
// while line_stb is high.
module scan_events #(
    parameter int LINE_W   = 9,
    parameter int SPR_LINE = 0,
    parameter int VBL_LINE = 384
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_stb,
    input  logic [LINE_W-1:0] line_num,
    input  logic              line_clr,
    input  logic              snd_irq,
    output logic              spr_o,
    output logic              vbl_o,
    output logic              snd_o
);
    localparam logic [LINE_W-1:0] SPR_L = LINE_W'(SPR_LINE);
    localparam logic [LINE_W-1:0] VBL_L = LINE_W'(VBL_LINE);

    logic spr_q, vbl_q, snd_q;
    logic spr_hit, vbl_hit;

    // Match the strobed scanline against the two event lines
    always_comb begin
        spr_hit = line_stb && (line_num == SPR_L);
        vbl_hit = line_stb && (line_num == VBL_L);
    end

    // Event flags with set priority and the sound sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spr_q <= 1'b0;
            vbl_q <= 1'b0;
            snd_q <= 1'b0;
        end else begin
            if (spr_hit)       spr_q <= 1'b1;
            else if (line_clr) spr_q <= 1'b0;
            if (vbl_hit)       vbl_q <= 1'b1;
            else if (line_clr) vbl_q <= 1'b0;
            snd_q <= snd_irq;
        end
    end

    assign spr_o = spr_q;
    assign vbl_o = vbl_q;
    assign snd_o = snd_q;
endmodule

// File: rtl/irq_route.sv
`timescale 1ns/1ps
// Per-processor mask and timer request.
// Gates the shared source levels with this processor's mask. The
// timer request is set by a fire and cleared by a mask access;
// a fire in the same cycle wins.
module irq_route
    import irqt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mask_we,
    input  logic [NSRC-1:0] mask_d,
    input  logic            pend_clr,
    input  logic            fire,
    input  logic [NSRC-1:1] ev_lvl,
    output logic [NSRC-1:0] irq_o,
    output logic            pend_o
);
    logic [NSRC-1:0] mask_q;
    logic            pend_q;

    // Mask storage and timer request with fire priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            pend_q <= 1'b0;
        end else begin
            if (mask_we)
                mask_q <= mask_d;
            if (fire)
                pend_q <= 1'b1;
            else if (pend_clr)
                pend_q <= 1'b0;
        end
    end

    // Gate every source with its enable bit
    always_comb begin
        irq_o = {ev_lvl, pend_q} & mask_q;
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/twin_irq_ctrl.sv
`timescale 1ns/1ps
// Interrupt controller for two processors with one shared interval
// timer. Decodes the host strobes, runs the timer and the video
// and sound sources, and builds one routed line set per processor.
// Assumes one host access per cycle.
module twin_irq_ctrl
    import irqt_pkg::*;
#(
    parameter int CNT_W    = 12,
    parameter int LINE_W   = 9,
    parameter int SPR_LINE = 0,
    parameter int VBL_LINE = 384
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [CNT_W-1:0]  host_wdata,
    output logic [CNT_W-1:0]  host_rdata,
    input  logic              hsync_tick,
    input  logic              timer_tick,
    input  logic              line_stb,
    input  logic [LINE_W-1:0] line_num,
    input  logic              line_clr,
    input  logic              snd_irq,
    output logic [NSRC-1:0]   irq_a,
    output logic [NSRC-1:0]   irq_b
);
    localparam int N_CPU = 2;

    logic             timer_fire;
    logic [1:0]       tmr_mode;
    logic [CNT_W-1:0] tmr_reload;
    logic [CNT_W-1:0] tmr_count;
    logic             ev_spr, ev_vbl, ev_snd;
    logic [NSRC-1:1]  ev_lvl;
    logic [N_CPU-1:0] pend_vec;
    logic [NSRC-1:0]  lines [N_CPU];

    interval_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .reload_we  (host_wr && host_addr == OFS_RELOAD),
        .reload_d   (host_wdata),
        .mode_we    (host_wr && host_addr == OFS_MODE),
        .mode_d     (host_wdata[1:0]),
        .hsync_tick (hsync_tick),
        .timer_tick (timer_tick),
        .count_o    (tmr_count),
        .reload_o   (tmr_reload),
        .mode_o     (tmr_mode),
        .fire_o     (timer_fire)
    );

    scan_events #(
        .LINE_W   (LINE_W),
        .SPR_LINE (SPR_LINE),
        .VBL_LINE (VBL_LINE)
    ) u_ev (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_stb (line_stb),
        .line_num (line_num),
        .line_clr (line_clr),
        .snd_irq  (snd_irq),
        .spr_o    (ev_spr),
        .vbl_o    (ev_vbl),
        .snd_o    (ev_snd)
    );

    // Assemble shared source levels in line-bit order
    always_comb begin
        ev_lvl = '0;
        ev_lvl[SRC_SOUND]  = ev_snd;
        ev_lvl[SRC_VBLANK] = ev_vbl;
        ev_lvl[SRC_SPRITE] = ev_spr;
    end

    for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
        localparam logic [ADDR_W-1:0] MY_OFS = ADDR_W'(int'(OFS_MASK0) + c);
        irq_route u_route (
            .clk      (clk),
            .rst_n    (rst_n),
            .mask_we  (host_wr && host_addr == MY_OFS),
            .mask_d   (host_wdata[NSRC-1:0]),
            .pend_clr ((host_wr || host_rd) && host_addr == MY_OFS),
            .fire     (timer_fire),
            .ev_lvl   (ev_lvl),
            .irq_o    (lines[c]),
            .pend_o   (pend_vec[c])
        );
    end

    assign irq_a      = lines[0];
    assign irq_b      = lines[1];
    assign host_rdata = tmr_count;
endmodule

// File: rtl/twin_irq_ctrl_chk.sv
`timescale 1ns/1ps
// Property checker for twin_irq_ctrl, attached with bind.
module twin_irq_ctrl_chk #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_wr,
    input logic             host_rd,
    input logic [1:0]       host_addr,
    input logic [CNT_W-1:0] host_wdata,
    input logic [CNT_W-1:0] host_rdata,
    input logic             line_stb,
    input logic             line_clr,
    input logic             snd_irq,
    input logic [3:0]       irq_a,
    input logic [3:0]       irq_b,
    input logic             fire,
    input logic [1:0]       mode,
    input logic [CNT_W-1:0] reload,
    input logic [1:0]       pend
);
    // R3
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && !(host_wr && host_addr == 2'd1)) |=> $stable(host_rdata));
    // R4
    wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> host_rdata == $past(reload));
    // R5
    final_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 2'd1 && host_wdata[1:0] == 2'd0 &&
         mode != 2'd0 && (&host_rdata)) |-> fire);
    // R6
    fire_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> pend == 2'b11);
    // R7
    mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 2'd2 && !fire) |=> !irq_a[0]);
    // R8
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == 2'd3 && !fire) |=> !irq_b[0]);
    // R9
    event_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_clr && !line_stb) |=> (irq_a[3:2] == 2'b00 && irq_b[3:2] == 2'b00));
    // R10
    sound_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !snd_irq |=> (!irq_a[1] && !irq_b[1]));
endmodule

bind twin_irq_ctrl twin_irq_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .line_stb   (line_stb),
    .line_clr   (line_clr),
    .snd_irq    (snd_irq),
    .irq_a      (irq_a),
    .irq_b      (irq_b),
    .fire       (timer_fire),
    .mode       (tmr_mode),
    .reload     (tmr_reload),
    .pend       (pend_vec)
);

// File: tb/twin_irq_ctrl_test.sv
`timescale 1ns/1ps
module twin_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [1:0]  host_addr = '0;
    logic [11:0] host_wdata = '0;
    logic [11:0] host_rdata;
    logic        hsync_tick = 1'b0, timer_tick = 1'b0;
    logic        line_stb = 1'b0, line_clr = 1'b0, snd_irq = 1'b0;
    logic [8:0]  line_num = '0;
    logic [3:0]  irq_a, irq_b;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    // bench model state
    logic [11:0] m_cnt, m_rel;
    logic [1:0]  m_mode;
    logic [3:0]  m_ma, m_mb;
    bit m_pa, m_pb, m_spr, m_vbl, m_snd;

    twin_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .hsync_tick(hsync_tick), .timer_tick(timer_tick), .line_stb(line_stb),
        .line_num(line_num), .line_clr(line_clr), .snd_irq(snd_irq),
        .irq_a(irq_a), .irq_b(irq_b)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [3:0] exp_lines(input logic [3:0] m, input bit p);
        return {m_spr, m_vbl, m_snd, p} & m;
    endfunction

    // model update, applied at each rising edge from the driven inputs
    task automatic model_step();
        bit adv, last, step, fire;
        if (!rst_n) begin
            m_cnt = '0; m_rel = '0; m_mode = '0; m_ma = '0; m_mb = '0;
            m_pa = 0; m_pb = 0; m_spr = 0; m_vbl = 0; m_snd = 0;
            return;
        end
        adv  = (m_mode == 2'd1 && hsync_tick) || (m_mode == 2'd3 && timer_tick);
        last = host_wr && host_addr == 2'd1 && m_mode != 2'd0 && host_wdata[1:0] == 2'd0;
        step = adv || last;
        fire = step && m_cnt == 12'hFFF;
        if (fire) m_cnt = m_rel; else if (step) m_cnt = m_cnt + 12'd1;
        if (fire) m_pa = 1; else if ((host_wr || host_rd) && host_addr == 2'd2) m_pa = 0;
        if (fire) m_pb = 1; else if ((host_wr || host_rd) && host_addr == 2'd3) m_pb = 0;
        if (host_wr) begin
            case (host_addr)
                2'd0: m_rel  = host_wdata;
                2'd1: m_mode = host_wdata[1:0];
                2'd2: m_ma   = host_wdata[3:0];
                default: m_mb = host_wdata[3:0];
            endcase
        end
        if (line_stb && line_num == 9'd0) m_spr = 1; else if (line_clr) m_spr = 0;
        if (line_stb && line_num == 9'd384) m_vbl = 1; else if (line_clr) m_vbl = 0;
        m_snd = snd_irq;
    endtask

    task automatic compare_all();
        logic [3:0] ea, eb;
        ea = exp_lines(m_ma, m_pa);
        eb = exp_lines(m_mb, m_pb);
        chk("R3 count readback", host_rdata, m_cnt);
        chk("R6 timer line A", irq_a[0], ea[0]);
        chk("R6 timer line B", irq_b[0], eb[0]);
        chk("R10 sound lines", {irq_a[1], irq_b[1]}, {ea[1], eb[1]});
        chk("R9 video lines", {irq_a[3:2], irq_b[3:2]}, {ea[3:2], eb[3:2]});
    endtask

    task automatic idle_inputs();
        host_wr = 0; host_rd = 0; host_addr = '0; host_wdata = '0;
        hsync_tick = 0; timer_tick = 0; line_stb = 0; line_clr = 0;
    endtask

    // one cycle: inputs already driven at a falling edge
    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
        idle_inputs();
    endtask

    task automatic wr(input logic [1:0] a, input logic [11:0] d);
        host_wr = 1; host_addr = a; host_wdata = d; cyc();
    endtask

    task automatic rd(input logic [1:0] a);
        host_rd = 1; host_addr = a; cyc();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: run hung (R1..all) got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        rst_n = 0;
        repeat (3) cyc();
        rst_n = 1;
        // R1 reset state
        chk("R1 count after reset", host_rdata, 12'h000);
        chk("R1 lines A after reset", irq_a, 4'h0);
        chk("R1 lines B after reset", irq_b, 4'h0);

        wr(2'd2, 12'h00F);
        wr(2'd3, 12'h001);
        wr(2'd0, 12'hFFE);
        chk("R2 restart write keeps count", host_rdata, 12'h000);
        // R3 mode 0 ignores ticks
        hsync_tick = 1; timer_tick = 1; cyc();
        chk("R3 stopped ignores ticks", host_rdata, 12'h000);
        wr(2'd1, 12'd1);
        timer_tick = 1; cyc();
        chk("R3 hsync mode ignores timer tick", host_rdata, 12'h000);
        for (int i = 0; i < 4095; i++) begin hsync_tick = 1; cyc(); end
        chk("R3 hsync mode counted", host_rdata, 12'hFFF);
        rd(2'd1);
        chk("R3 read returns count", host_rdata, 12'hFFF);
        hsync_tick = 1; cyc();
        chk("R4 wrap loads restart", host_rdata, 12'hFFE);
        chk("R6 fire reaches A", irq_a[0], 1'b1);
        chk("R6 fire reaches B", irq_b[0], 1'b1);
        rd(2'd2);
        chk("R8 read clears A", irq_a[0], 1'b0);
        chk("R8 read leaves B", irq_b[0], 1'b1);
        wr(2'd3, 12'h001);
        chk("R7 mask write clears B", irq_b[0], 1'b0);
        wr(2'd1, 12'd2);
        timer_tick = 1; hsync_tick = 1; cyc();
        chk("R3 mode 2 does not count", host_rdata, 12'hFFE);
        wr(2'd1, 12'd3);
        timer_tick = 1; cyc();
        chk("R3 clock mode counted", host_rdata, 12'hFFF);
        wr(2'd1, 12'd0);
        chk("R5 final step wraps", host_rdata, 12'hFFE);
        chk("R5 final step fires", irq_a[0], 1'b1);
        wr(2'd1, 12'd0);
        chk("R5 stop to stop no step", host_rdata, 12'hFFE);
        wr(2'd1, 12'd3);
        timer_tick = 1; cyc();
        rd(2'd2);
        timer_tick = 1; host_wr = 1; host_addr = 2'd2; host_wdata = 12'h00F; cyc();
        chk("R7 fire wins over mask write", irq_a[0], 1'b1);
        wr(2'd1, 12'd0);
        // R10 sound path
        snd_irq = 1; cyc();
        chk("R10 sound to A", irq_a[1], 1'b1);
        chk("R10 sound masked for B", irq_b[1], 1'b0);
        snd_irq = 0; cyc();
        chk("R10 sound released", irq_a[1], 1'b0);
        // R9 video events
        line_stb = 1; line_num = 9'd0; cyc();
        chk("R9 sprite event", irq_a[3], 1'b1);
        line_stb = 1; line_num = 9'd100; cyc();
        chk("R9 other line no vblank", irq_a[2], 1'b0);
        line_stb = 1; line_num = 9'd384; line_clr = 1; cyc();
        chk("R9 set wins over clear", irq_a[3:2], 2'b01);
        line_clr = 1; cyc();
        chk("R9 clear drops events", irq_a[3:2], 2'b00);

        // random phase, model compared every cycle
        for (int n = 0; n < 6000; n++) begin
            int r;
            r = $urandom % 100;
            if (r < 7) begin
                host_wr = 1; host_addr = 2'($urandom);
                host_wdata = ($urandom % 2) ? (12'hFF0 | 12'($urandom % 16)) : 12'($urandom);
            end else if (r < 11) begin
                host_rd = 1; host_addr = 2'($urandom);
            end
            hsync_tick = ($urandom % 2) == 0;
            timer_tick = ($urandom % 3) == 0;
            line_stb   = ($urandom % 6) == 0;
            case ($urandom % 4)
                0: line_num = 9'd0;
                1: line_num = 9'd384;
                default: line_num = 9'($urandom);
            endcase
            line_clr = ($urandom % 10) == 0;
            if ($urandom % 8 == 0) snd_irq = ~snd_irq;
            cyc();
        end
        finish_run();
    end
endmodule